// File: doc/BRIEF.md
# Capture/Compare Timer with Armed Flag Clearing

This block is a 16-bit free-running timer. It has two input-capture channels and two output-compare channels, and all of them report through one status byte. The counter advances once for each cycle in which the external prescaler `tick` is high. A rising edge on a capture pin, seen after two synchronizer flops, copies the counter into that channel's capture register. A tick that arrives while the counter equals a compare register counts as a compare match. A match toggles that channel's output pin.

Software reaches the block through a byte-wide register port that has separate read and write strobes. The read data is combinational from the address. The block has no streaming data path, so every pin is a plain level or strobe and there is no valid/ready back-pressure. A flag is cleared in two steps:

1. Read the status byte. This arms a pending-clear bit for every flag that is set at that moment.
2. Read or write the low byte of the register that belongs to the flag. This clears the flag, but only if its pending-clear bit is armed.

A disable bit in the status byte freezes the counter and forces the compare outputs low. Register access keeps working while the block is disabled. A mode bit makes the counter restart from zero after the tick at the compare-2 value.

Top module: `cc_timer`

Register addresses: 0 status, 1 counter high, 2 counter low, 3 counter low alias, 4/5 capture-1 high/low, 6/7 capture-2 high/low, 8/9 compare-1 high/low, 10/11 compare-2 high/low, 12 mode (bit 0 = restart at compare-2). Unmapped addresses read 0.

## Requirements
- R1: After reset the status byte, the counter, the capture and compare registers, the mode bit and both compare outputs are 0.
- R2: Status layout: bit 7 capture-1 flag, bit 6 compare-1 flag, bit 5 overflow flag, bit 4 capture-2 flag, bit 3 compare-2 flag, bit 2 disable. Bits 1:0 read 0. A status write changes only bit 2.
- R3: The counter adds 1 (modulo 2^16) on each cycle with `tick`=1 and disable=0. A tick at FFFFh sets the overflow flag as the counter wraps to 0000h.
- R4: The overflow flag clears on an access to address 2 after an arming status read. Reads of address 3 never clear it.
- R5: A rising edge on `cap_in[i]`, after two synchronizer flops, latches the counter into capture register i and sets that channel's capture flag.
- R6: A capture flag clears on an access to its capture low byte (address 5 or 7) after an arming status read.
- R7: A tick while the counter equals compare register i (with disable=0) sets compare flag i and toggles `cmp_out[i]`.
- R8: A compare flag clears on an access to its compare low byte (address 9 or 11) after an arming status read.
- R9: A low-byte access clears only flags that were set at the time of the most recent status read. A flag set after that read survives. A low-byte access with no prior status read clears nothing.
- R10: When a set event and an armed clear for the same flag fall in the same cycle, the flag stays set.
- R11: With disable=1 the counter holds, no compare match occurs, and both `cmp_out` pins are 0. Register reads and writes still work. A write to address 1, 2 or 3 resets the counter to 0 in any state.
- R12: With mode bit 0 set, a tick at the compare-2 value sets the compare-2 flag and returns the counter to 0.
- R13: With parameter `DUAL_CH`=0, status bits 4 and 3 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| cap_in | input | 2 | Asynchronous capture pins |
| tick | input | 1 | Prescaler count enable |
| cmp_out | output | 2 | Compare toggle outputs, forced low when disabled |

## Verification
The bench goes after the following corner cases:

- **Alias read.** It reads the counter-low alias between the arming read and the real low-byte access. A design that decoded the alias as the clearing address would drop the overflow flag early.
- **Late capture.** A capture edge is placed after the arming status read. A design that cleared all flags instead of only the armed ones would lose that event.
- **Capture on the clearing access.** A capture edge is timed to land on the exact cycle of the clearing access. If clear took priority over set, the flag would read 0 afterwards.
- **Disable and restart.** The bench checks that the counter holds while disabled, that a counter write still resets it, and that the counter returns to 0 at the compare-2 value in restart mode. A missing gate or an off-by-one in the restart shows up at once in the cycle-by-cycle comparison of every read value and output pin.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int CW = 16;
  localparam int AW = 4;
  localparam int NCH = 2;
  typedef logic [CW-1:0] cnt_t;

  localparam logic [AW-1:0] A_STAT = 4'd0;
  localparam logic [AW-1:0] A_CNTH = 4'd1;
  localparam logic [AW-1:0] A_CNTL = 4'd2;
  localparam logic [AW-1:0] A_ALTL = 4'd3;
  localparam logic [AW-1:0] A_IC1H = 4'd4;
  localparam logic [AW-1:0] A_IC1L = 4'd5;
  localparam logic [AW-1:0] A_IC2H = 4'd6;
  localparam logic [AW-1:0] A_IC2L = 4'd7;
  localparam logic [AW-1:0] A_OC1H = 4'd8;
  localparam logic [AW-1:0] A_OC1L = 4'd9;
  localparam logic [AW-1:0] A_OC2H = 4'd10;
  localparam logic [AW-1:0] A_OC2L = 4'd11;
  localparam logic [AW-1:0] A_MODE = 4'd12;

  // index into the 5-bit flag vector; status byte = {flags, disable, 2'b00}
  localparam int F_IC1 = 4;
  localparam int F_OC1 = 3;
  localparam int F_OVF = 2;
  localparam int F_IC2 = 1;
  localparam int F_OC2 = 0;
  localparam int NFLG  = 5;
endpackage

// File: rtl/cct_counter.sv
module cct_counter
  import cct_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic halt,
  input  logic zero,
  input  logic wrap_en,
  input  cnt_t wrap_at,
  output cnt_t cnt,
  output logic adv,
  output logic ovf_evt
);
  assign adv     = tick & ~halt;
  assign ovf_evt = adv && (cnt == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (zero) begin
      cnt <= '0;
    end else if (adv) begin
      if (wrap_en && cnt == wrap_at) cnt <= '0;
      else                           cnt <= cnt + cnt_t'(1);
    end
  end

  // R11
  frozen_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !zero) |=> $stable(cnt));
endmodule

// File: rtl/cct_capture.sv
module cct_capture
  import cct_pkg::*;
#(
  parameter int N = NCH
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        pin,
  input  cnt_t                cnt,
  output logic [N-1:0]        evt,
  output logic [N-1:0][CW-1:0] cap_q
);
  logic [N-1:0] s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= pin;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign evt = s2 & ~s3;

  for (genvar i = 0; i < N; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cap_q[i] <= '0;
      else if (evt[i]) cap_q[i] <= cnt;
    end

    // R5
    latch_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> cap_q[i] == $past(cnt));
  end
endmodule

// File: rtl/cct_compare.sv
module cct_compare
  import cct_pkg::*;
#(
  parameter int N = NCH
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 halt,
  input  cnt_t                 cnt,
  input  logic [N-1:0][CW-1:0] oc,
  output logic [N-1:0]         match,
  output logic [N-1:0]         pin
);
  logic [N-1:0] tog;

  for (genvar i = 0; i < N; i++) begin : g_ch
    assign match[i] = adv && (cnt == oc[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        tog[i] <= 1'b0;
      else if (match[i]) tog[i] <= ~tog[i];
    end

    // R7
    toggle_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match[i] |=> tog[i] != $past(tog[i]));
  end

  assign pin = tog & {N{~halt}};
endmodule

// File: rtl/cct_status.sv
module cct_status
  import cct_pkg::*;
#(
  parameter bit DUAL = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NFLG-1:0] set_evt,
  input  logic [NFLG-1:0] acc_evt,
  input  logic            stat_rd,
  input  logic            dis_we,
  input  logic            dis_d,
  output logic [7:0]      stat,
  output logic            dis_q
);
  localparam logic [NFLG-1:0] FMASK = DUAL ? 5'b11111 : 5'b11100;

  logic [NFLG-1:0] flg, pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg   <= '0;
      pend  <= '0;
      dis_q <= 1'b0;
    end else begin
      flg  <= (set_evt & FMASK) | (flg & ~(acc_evt & pend));
      pend <= stat_rd ? (pend | flg) : (pend & ~acc_evt);
      if (dis_we) dis_q <= dis_d;
    end
  end

  assign stat = {flg, dis_q, 2'b00};

  for (genvar k = 0; k < NFLG; k++) begin : g_chk
    if (FMASK[k]) begin : g_live
      // R10
      set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt[k] |=> flg[k]);
      // R9
      armed_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flg[k]) |-> $past(pend[k] && acc_evt[k]));
    end
  end
endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import cct_pkg::*;
#(
  parameter bit DUAL_CH = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic         bus_rd,
  input  logic         bus_wr,
  input  logic [7:0]   bus_wdata,
  output logic [7:0]   bus_rdata,
  input  logic [NCH-1:0] cap_in,
  input  logic         tick,
  output logic [NCH-1:0] cmp_out
);
  logic                   any_acc, stat_rd, cnt_zero, dis_q, mode_q;
  logic                   adv, ovf_evt;
  cnt_t                   cnt;
  logic [NCH-1:0]         cap_evt, match;
  logic [NCH-1:0][CW-1:0] cap_q, oc_q;
  logic [NFLG-1:0]        set_evt, acc_evt;
  logic [7:0]             stat;

  assign any_acc  = bus_rd | bus_wr;
  assign stat_rd  = bus_rd && (bus_addr == A_STAT);
  assign cnt_zero = bus_wr && (bus_addr == A_CNTH || bus_addr == A_CNTL ||
                               bus_addr == A_ALTL);

  assign set_evt = {cap_evt[0], match[0], ovf_evt, cap_evt[1], match[1]};
  assign acc_evt = {any_acc && bus_addr == A_IC1L,
                    any_acc && bus_addr == A_OC1L,
                    any_acc && bus_addr == A_CNTL,
                    any_acc && bus_addr == A_IC2L,
                    any_acc && bus_addr == A_OC2L};

  for (genvar i = 0; i < NCH; i++) begin : g_oc
    localparam logic [AW-1:0] HI = A_OC1H + AW'(2 * i);
    localparam logic [AW-1:0] LO = A_OC1L + AW'(2 * i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        oc_q[i] <= '0;
      end else if (bus_wr) begin
        if (bus_addr == HI) oc_q[i][CW-1:8] <= bus_wdata;
        if (bus_addr == LO) oc_q[i][7:0]    <= bus_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               mode_q <= 1'b0;
    else if (bus_wr && bus_addr == A_MODE)    mode_q <= bus_wdata[0];
  end

  cct_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .halt(dis_q), .zero(cnt_zero),
    .wrap_en(mode_q), .wrap_at(oc_q[1]), .cnt(cnt), .adv(adv), .ovf_evt(ovf_evt)
  );

  cct_capture #(.N(NCH)) u_cap (
    .clk(clk), .rst_n(rst_n), .pin(cap_in), .cnt(cnt), .evt(cap_evt), .cap_q(cap_q)
  );

  cct_compare #(.N(NCH)) u_cmp (
    .clk(clk), .rst_n(rst_n), .adv(adv), .halt(dis_q), .cnt(cnt), .oc(oc_q),
    .match(match), .pin(cmp_out)
  );

  cct_status #(.DUAL(DUAL_CH)) u_st (
    .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .acc_evt(acc_evt),
    .stat_rd(stat_rd), .dis_we(bus_wr && bus_addr == A_STAT),
    .dis_d(bus_wdata[2]), .stat(stat), .dis_q(dis_q)
  );

  always_comb begin
    case (bus_addr)
      A_STAT:         bus_rdata = stat;
      A_CNTH:         bus_rdata = cnt[CW-1:8];
      A_CNTL, A_ALTL: bus_rdata = cnt[7:0];
      A_IC1H:         bus_rdata = cap_q[0][CW-1:8];
      A_IC1L:         bus_rdata = cap_q[0][7:0];
      A_IC2H:         bus_rdata = cap_q[1][CW-1:8];
      A_IC2L:         bus_rdata = cap_q[1][7:0];
      A_OC1H:         bus_rdata = oc_q[0][CW-1:8];
      A_OC1L:         bus_rdata = oc_q[0][7:0];
      A_OC2H:         bus_rdata = oc_q[1][CW-1:8];
      A_OC2L:         bus_rdata = oc_q[1][7:0];
      A_MODE:         bus_rdata = {7'd0, mode_q};
      default:        bus_rdata = 8'd0;
    endcase
  end

  // R3
  overflow_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> stat[5]);
endmodule

// File: tb/sim_cc_timer.sv
module sim_cc_timer;
  import cct_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, rd, wr, tick;
  logic [3:0] addr;
  logic [7:0] wd;
  logic [1:0] cap;
  wire  [7:0] rdata, rdata1;
  wire  [1:0] cout, cout1;

  cc_timer #(.DUAL_CH(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_rd(rd), .bus_wr(wr),
    .bus_wdata(wd), .bus_rdata(rdata), .cap_in(cap), .tick(tick), .cmp_out(cout));
  cc_timer #(.DUAL_CH(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_rd(rd), .bus_wr(wr),
    .bus_wdata(wd), .bus_rdata(rdata1), .cap_in(cap), .tick(tick), .cmp_out(cout1));

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] q, q1;
  int tgt, a0;
  bit prev0;

  // reference model state
  int m_cnt, m_ic[2], m_oc[2];
  logic [4:0] m_flg, m_pend, m_flg1, m_pend1;
  bit m_dis, m_pwm;
  bit [1:0] m_tog, s1, s2, s3;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] nxt(input logic [4:0] f, input logic [4:0] p,
      input logic [4:0] s, input logic [4:0] c, input bit srd, input logic [4:0] mk);
    logic [4:0] nf, np;
    nf = (s & mk) | (f & ~(c & p));
    np = srd ? (p | f) : (p & ~c);
    return {nf, np};
  endfunction

  function automatic int exp_rd(input logic [3:0] a, input logic [4:0] f);
    case (a)
      A_STAT: return {f, m_dis, 2'b00};
      A_CNTH: return (m_cnt >> 8) & 255;
      A_CNTL, A_ALTL: return m_cnt & 255;
      A_IC1H: return (m_ic[0] >> 8) & 255;
      A_IC1L: return m_ic[0] & 255;
      A_IC2H: return (m_ic[1] >> 8) & 255;
      A_IC2L: return m_ic[1] & 255;
      A_OC1H: return (m_oc[0] >> 8) & 255;
      A_OC1L: return m_oc[0] & 255;
      A_OC2H: return (m_oc[1] >> 8) & 255;
      A_OC2L: return m_oc[1] & 255;
      A_MODE: return int'(m_pwm);
      default: return 0;
    endcase
  endfunction

  function automatic string tag_for(input logic [3:0] a);
    case (a)
      A_STAT: return "R2 status";
      A_CNTH, A_CNTL, A_ALTL: return "R3 counter";
      A_IC1H, A_IC1L, A_IC2H, A_IC2L: return "R5 capture";
      A_OC1H, A_OC1L, A_OC2H, A_OC2L: return "R7 compare reg";
      default: return "R12 mode";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_ic = '{0, 0}; m_oc = '{0, 0};
      m_flg = 0; m_pend = 0; m_flg1 = 0; m_pend1 = 0;
      m_dis = 0; m_pwm = 0; m_tog = 0; s1 = 0; s2 = 0; s3 = 0;
    end else begin
      bit adv, ovf, acc, srd;
      bit [1:0] mt, ev;
      logic [4:0] sv, cv;
      logic [9:0] r;
      adv = tick && !m_dis;
      ovf = adv && m_cnt == 65535;
      for (int i = 0; i < 2; i++) begin
        mt[i] = adv && m_cnt == m_oc[i];
        ev[i] = s2[i] && !s3[i];
      end
      acc = rd || wr;
      srd = rd && addr == A_STAT;
      sv = {ev[0], mt[0], ovf, ev[1], mt[1]};
      cv = {acc && addr == A_IC1L, acc && addr == A_OC1L, acc && addr == A_CNTL,
            acc && addr == A_IC2L, acc && addr == A_OC2L};
      r = nxt(m_flg, m_pend, sv, cv, srd, 5'b11111);
      m_flg = r[9:5]; m_pend = r[4:0];
      r = nxt(m_flg1, m_pend1, sv, cv, srd, 5'b11100);
      m_flg1 = r[9:5]; m_pend1 = r[4:0];
      for (int i = 0; i < 2; i++) if (ev[i]) m_ic[i] = m_cnt;
      if (wr && (addr == A_CNTH || addr == A_CNTL || addr == A_ALTL)) m_cnt = 0;
      else if (adv) m_cnt = (m_pwm && m_cnt == m_oc[1]) ? 0 : (m_cnt + 1) & 65535;
      m_tog = m_tog ^ mt;
      if (wr) begin
        case (addr)
          A_OC1H: m_oc[0] = (m_oc[0] & 255) | (int'(wd) << 8);
          A_OC1L: m_oc[0] = (m_oc[0] & 65280) | int'(wd);
          A_OC2H: m_oc[1] = (m_oc[1] & 255) | (int'(wd) << 8);
          A_OC2L: m_oc[1] = (m_oc[1] & 65280) | int'(wd);
          A_MODE: m_pwm = wd[0];
          A_STAT: m_dis = wd[2];
          default: ;
        endcase
      end
      s3 = s2; s2 = s1; s1 = cap;
    end
  end

  // every-cycle comparison against the model
  always @(posedge clk) begin
    #3;
    if (rst_n && !done) begin
      chk(tag_for(addr), rdata, exp_rd(addr, m_flg));
      chk("R11 outputs", cout, m_dis ? 0 : m_tog);
      chk("R13 outputs", cout1, m_dis ? 0 : m_tog);
      if (addr == A_STAT) chk("R13 status", rdata1, exp_rd(addr, m_flg1));
    end
  end

  task automatic op(input bit r, input bit w, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; rd = r; wr = w; wd = d;
    #4;
    q = rdata; q1 = rdata1;
    @(negedge clk);
    rd = 0; wr = 0;
  endtask

  task automatic pulse(input int ch);
    @(negedge clk); cap[ch] = 1'b1;
    repeat (4) @(negedge clk);
    cap[ch] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; addr = 0; rd = 0; wr = 0; wd = 0; cap = 0; tick = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    op(1, 0, A_STAT, 0); chk("R1 status", q, 0);
    op(1, 0, A_CNTL, 0); chk("R1 counter", q, 0);
    op(1, 0, A_OC2H, 0); chk("R1 compare reg", q, 0);
    chk("R1 outputs", cout, 0);

    // R2 only the disable bit is writable, reserved bits read 0
    op(0, 1, A_STAT, 8'hFF); op(1, 0, A_STAT, 0); chk("R2 writable bits", q, 8'h04);
    op(0, 1, A_STAT, 8'h00); op(1, 0, A_STAT, 0); chk("R2 cleared", q, 0);

    // R3 counting through the wrap
    tick = 1;
    repeat (65540) @(negedge clk);
    tick = 0;
    op(1, 0, A_STAT, 0); chk("R3 overflow flag", q & 8'h20, 8'h20);
    op(1, 0, A_CNTH, 0); chk("R3 counter after wrap", q, (m_cnt >> 8) & 255);

    // R4 alias read does not clear; counter low access does
    op(1, 0, A_ALTL, 0);
    op(1, 0, A_STAT, 0); chk("R4 alias leaves flag", q & 8'h20, 8'h20);
    op(1, 0, A_CNTL, 0);
    op(1, 0, A_OC1L, 0);
    op(1, 0, A_OC2L, 0);
    op(1, 0, A_STAT, 0); chk("R4 R8 flags cleared", q, 0);

    // R5 R6 capture channel 1
    tick = 1; pulse(0); tick = 0;
    op(1, 0, A_STAT, 0); chk("R5 capture flag", q & 8'h80, 8'h80);
    op(1, 0, A_IC1H, 0); chk("R5 capture high", q, (m_ic[0] >> 8) & 255);
    op(1, 0, A_IC1L, 0); chk("R5 capture low", q, m_ic[0] & 255);
    op(1, 0, A_STAT, 0); chk("R6 capture flag cleared", q & 8'h80, 0);

    // R7 R8 compare channel 1
    tgt = (m_cnt + 30) & 65535;
    op(0, 1, A_OC1H, 8'((tgt >> 8) & 255));
    op(0, 1, A_OC1L, 8'(tgt & 255));
    prev0 = cout[0];
    tick = 1; repeat (50) @(negedge clk); tick = 0;
    op(1, 0, A_STAT, 0); chk("R7 compare flag", q & 8'h40, 8'h40);
    chk("R7 output toggled", int'(cout[0]), int'(!prev0));
    op(1, 0, A_OC1L, 0);
    op(1, 0, A_STAT, 0); chk("R8 compare flag cleared", q & 8'h40, 0);

    // R9 no clear without an arming read; R13 reduced variant hides channel 2
    pulse(1);
    op(1, 0, A_IC2L, 0);
    op(1, 0, A_STAT, 0); chk("R9 unarmed access", q & 8'h10, 8'h10);
    chk("R13 variant bits", q1 & 8'h18, 0);
    pulse(0);
    op(1, 0, A_IC1L, 0);
    op(1, 0, A_STAT, 0); chk("R9 late event kept", q & 8'h80, 8'h80);
    op(1, 0, A_IC2L, 0);
    op(1, 0, A_STAT, 0); chk("R6 channel 2 cleared", q & 8'h10, 0);

    // R10 capture edge lands on the armed clearing access
    @(negedge clk); cap[0] = 1'b1;
    @(negedge clk);
    op(1, 0, A_IC1L, 0);
    cap[0] = 1'b0;
    repeat (3) @(negedge clk);
    op(1, 0, A_STAT, 0); chk("R10 set wins", q & 8'h80, 8'h80);

    // R11 disable
    tick = 1;
    op(0, 1, A_STAT, 8'h04);
    op(1, 0, A_CNTL, 0); a0 = q;
    repeat (10) @(negedge clk);
    op(1, 0, A_CNTL, 0); chk("R11 counter frozen", q, a0);
    chk("R11 outputs low", cout, 0);
    op(0, 1, A_OC2L, 8'h33); op(1, 0, A_OC2L, 0); chk("R11 access works", q, 8'h33);
    op(0, 1, A_CNTH, 0); op(1, 0, A_CNTL, 0); chk("R11 counter reset", q, 0);
    op(0, 1, A_STAT, 8'h00);
    repeat (5) @(negedge clk);
    op(1, 0, A_CNTL, 0); chk("R11 resumes", int'(q != 0), 1);
    tick = 0;

    // R12 restart at compare-2
    op(0, 1, A_OC2H, 8'h00); op(0, 1, A_OC2L, 8'h05); op(0, 1, A_MODE, 8'h01);
    op(1, 0, A_STAT, 0); op(1, 0, A_OC2L, 0);
    op(0, 1, A_CNTL, 0);
    tick = 1; repeat (33) @(negedge clk); tick = 0;
    op(1, 0, A_CNTL, 0); chk("R12 bounded count", int'(q <= 5), 1);
    chk("R12 count value", q, m_cnt & 255);
    op(1, 0, A_CNTH, 0); chk("R12 high byte", q, 0);
    op(1, 0, A_STAT, 0); chk("R12 compare-2 flag", q & 8'h08, 8'h08);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule